// File: doc/BRIEF.md
# External Data Memory Address Router

This block sits between the external-data move operations of a small 8-bit CPU and two memories. One is an on-chip data RAM. The other is an off-chip memory reached over a 12-bit address bus. Each access arrives as a one-cycle strobe together with the current pointer state. That state is either a page register and one of two 8-bit index registers (narrow access), or a 16-bit data pointer (wide access). The block forms the effective address from that state. It then sends the access to the on-chip RAM or to the off-chip bus, according to a 2-bit mode field and a size parameter.

For off-chip accesses, the block drives a 12-bit address bus value with two separate output enables, one for the low byte and one for the upper nibble. When the upper-nibble enable is low, the pins can keep whatever the port latches hold. The off-chip bus timing, address/data multiplexing and instruction decoding live elsewhere. The on-chip RAM is a synchronous byte array inside the block.

Top module: `xr_router_top`

## Requirements
- R1: Mode 2'b00 sends every access on-chip. The RAM location used is the effective address modulo ONCHIP_BYTES, so address ONCHIP_BYTES+k reaches the same byte as k.
- R2: A narrow access (accWide=0) uses the effective address {pageReg, index}, where index is idx0 when idxSel=0 and idx1 when idxSel=1.
- R3: A wide access (accWide=1) uses the effective address dptr[15:0].
- R4: In modes 2'b01 and 2'b10, an effective address below ONCHIP_BYTES goes on-chip, and an address equal to or above ONCHIP_BYTES goes off-chip.
- R5: Mode 2'b11 sends every access off-chip, whatever the address.
- R6: In mode 2'b01, a narrow off-chip access raises loAddrEn with hiAddrEn low. busAddr[7:0] is the index and busAddr[11:8] reads 0.
- R7: A wide off-chip access in any mode raises both enables, and busAddr equals the effective address bits [11:0].
- R8: In modes 2'b10 and 2'b11, a narrow off-chip access raises both enables, with busAddr = {pageReg[3:0], index}.
- R9: onChipSel, offChipReq and both enables are high only in the cycle after a strobe edge. A cycle with no strobe leaves them all low. busAddr changes only on off-chip accesses and otherwise keeps its last value.
- R10: onChipSel and offChipReq are never high together. An on-chip write (accWrite=1) stores wrData. An on-chip read returns the byte in ramRdData in the same cycle as onChipSel. ramRdData changes only on on-chip reads, and off-chip accesses leave the RAM untouched.
- R11: While rstN is low, all selects, enables, busAddr and ramRdData are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accStrobe | input | 1 | One access per cycle in which it is high |
| accWide | input | 1 | 1: data pointer access, 0: page/index access |
| accWrite | input | 1 | 1: write, 0: read |
| modeSel | input | 2 | Routing mode 00/01/10/11 |
| idxSel | input | 1 | Selects idx1 when 1, idx0 when 0 |
| idx0 | input | 8 | Index register 0 |
| idx1 | input | 8 | Index register 1 |
| pageReg | input | 8 | Page register (high address byte) |
| dptr | input | 16 | Data pointer |
| wrData | input | 8 | Write data for on-chip RAM |
| onChipSel | output | 1 | Access went to on-chip RAM |
| offChipReq | output | 1 | Access goes to off-chip memory |
| busAddr | output | 12 | Off-chip address bus value |
| hiAddrEn | output | 1 | Drive enable for busAddr[11:8] |
| loAddrEn | output | 1 | Drive enable for busAddr[7:0] |
| ramRdData | output | 8 | On-chip read data |

## Verification
An on-chip RAM write and the next access's route decision and read can fall in consecutive clock edges. With the strobe held high back to back, a read of a byte written one edge earlier must already see the new value. An off-chip access in that same stream must leave both the RAM and ramRdData unchanged. The bench provokes this with directed write-then-read pairs and with a long unbroken random stream, and judges each cycle against its own byte-array model.

// File: rtl/xr_pkg.sv
package xr_pkg;
  typedef enum logic [1:0] {
    MODE_LOCAL     = 2'b00,
    MODE_SPLIT_LOW = 2'b01,
    MODE_SPLIT_PG  = 2'b10,
    MODE_REMOTE    = 2'b11
  } xmode_e;

  // Strobes from the route decision to the address datapath.
  typedef struct packed {
    logic takeOn;
    logic takeOff;
    logic driveHi;
    logic driveLo;
  } route_s;
endpackage

// File: rtl/xr_route_ctrl.sv
module xr_route_ctrl
  import xr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       accStrobe,
  input  logic       accWide,
  input  logic [1:0] modeSel,
  input  logic       aboveOnChip,
  output route_s     route
);
  xmode_e mode;
  logic   offTarget;

  assign mode = xmode_e'(modeSel);

  always_comb begin
    unique case (mode)
      MODE_LOCAL:  offTarget = 1'b0;
      MODE_REMOTE: offTarget = 1'b1;
      default:     offTarget = aboveOnChip;
    endcase
  end

  always_comb begin
    route.takeOn  = accStrobe & ~offTarget;
    route.takeOff = accStrobe & offTarget;
    route.driveLo = accStrobe & offTarget;
    route.driveHi = accStrobe & offTarget & (accWide | (mode != MODE_SPLIT_LOW));
  end

  // R4
  split_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    accStrobe && (modeSel == 2'b01 || modeSel == 2'b10) && !aboveOnChip |-> route.takeOn);
endmodule

// File: rtl/xr_addr_path.sv
module xr_addr_path
  import xr_pkg::*;
#(
  parameter int ONCHIP_BYTES = 1024,
  parameter int BUS_W        = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accWide,
  input  logic             accWrite,
  input  logic             idxSel,
  input  logic [7:0]       idx0,
  input  logic [7:0]       idx1,
  input  logic [7:0]       pageReg,
  input  logic [15:0]      dptr,
  input  logic [7:0]       wrData,
  input  route_s           route,
  output logic             aboveOnChip,
  output logic             onChipSel,
  output logic             offChipReq,
  output logic [BUS_W-1:0] busAddr,
  output logic             hiAddrEn,
  output logic             loAddrEn,
  output logic [7:0]       ramRdData
);
  localparam int RAM_AW = $clog2(ONCHIP_BYTES);
  localparam int HI_W   = BUS_W - 8;
  localparam logic [16:0] BOUNDARY = 17'(ONCHIP_BYTES);

  logic [15:0]       effAddr;
  logic [7:0]        index;
  logic [RAM_AW-1:0] ramIdx;
  logic [7:0]        ram [ONCHIP_BYTES];

  assign index       = idxSel ? idx1 : idx0;
  assign effAddr     = accWide ? dptr : {pageReg, index};
  assign aboveOnChip = ({1'b0, effAddr} >= BOUNDARY);
  assign ramIdx      = effAddr[RAM_AW-1:0];

  always_ff @(posedge clk) begin
    if (route.takeOn && accWrite) ram[ramIdx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      onChipSel  <= 1'b0;
      offChipReq <= 1'b0;
      hiAddrEn   <= 1'b0;
      loAddrEn   <= 1'b0;
      busAddr    <= '0;
      ramRdData  <= '0;
    end else begin
      onChipSel  <= route.takeOn;
      offChipReq <= route.takeOff;
      hiAddrEn   <= route.driveHi;
      loAddrEn   <= route.driveLo;
      if (route.takeOff)
        busAddr <= route.driveHi ? effAddr[BUS_W-1:0] : {{HI_W{1'b0}}, effAddr[7:0]};
      if (route.takeOn && !accWrite)
        ramRdData <= ram[ramIdx];
    end
  end

  // R10
  sel_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({onChipSel, offChipReq}));
  // R6
  hi_needs_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    hiAddrEn |-> (loAddrEn && offChipReq));
  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !route.takeOff |=> $stable(busAddr));
endmodule

// File: rtl/xr_router_top.sv
module xr_router_top
  import xr_pkg::*;
#(
  parameter int ONCHIP_BYTES = 1024,
  parameter int BUS_W        = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accStrobe,
  input  logic             accWide,
  input  logic             accWrite,
  input  logic [1:0]       modeSel,
  input  logic             idxSel,
  input  logic [7:0]       idx0,
  input  logic [7:0]       idx1,
  input  logic [7:0]       pageReg,
  input  logic [15:0]      dptr,
  input  logic [7:0]       wrData,
  output logic             onChipSel,
  output logic             offChipReq,
  output logic [BUS_W-1:0] busAddr,
  output logic             hiAddrEn,
  output logic             loAddrEn,
  output logic [7:0]       ramRdData
);
  route_s route;
  logic   aboveOnChip;

  xr_route_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .accStrobe(accStrobe), .accWide(accWide),
    .modeSel(modeSel), .aboveOnChip(aboveOnChip), .route(route)
  );

  xr_addr_path #(.ONCHIP_BYTES(ONCHIP_BYTES), .BUS_W(BUS_W)) i_path (
    .clk(clk), .rstN(rstN), .accWide(accWide), .accWrite(accWrite),
    .idxSel(idxSel), .idx0(idx0), .idx1(idx1), .pageReg(pageReg),
    .dptr(dptr), .wrData(wrData), .route(route), .aboveOnChip(aboveOnChip),
    .onChipSel(onChipSel), .offChipReq(offChipReq), .busAddr(busAddr),
    .hiAddrEn(hiAddrEn), .loAddrEn(loAddrEn), .ramRdData(ramRdData)
  );

  // R1
  mode_local_chk: assert property (@(posedge clk) disable iff (!rstN)
    accStrobe && modeSel == 2'b00 |=> onChipSel && !offChipReq);
  // R5
  mode_remote_chk: assert property (@(posedge clk) disable iff (!rstN)
    accStrobe && modeSel == 2'b11 |=> offChipReq && !onChipSel);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accStrobe |=> !onChipSel && !offChipReq && !hiAddrEn && !loAddrEn);
endmodule

// File: tb/test_xr_router_top.sv
module test_xr_router_top;
  localparam int ONCHIP = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accStrobe = 1'b0, accWide = 1'b0, accWrite = 1'b0, idxSel = 1'b0;
  logic [1:0]  modeSel = 2'b00;
  logic [7:0]  idx0 = '0, idx1 = '0, pageReg = '0, wrData = '0;
  logic [15:0] dptr = '0;
  logic        onChipSel, offChipReq, hiAddrEn, loAddrEn;
  logic [11:0] busAddr;
  logic [7:0]  ramRdData;

  int checks = 0;
  int failures = 0;
  logic [7:0]  mem [ONCHIP];
  logic [11:0] expBus = '0;
  logic [7:0]  expRd = '0;

  always #2.5 clk = ~clk;

  xr_router_top i_xr_router_top (
    .clk(clk), .rstN(rstN), .accStrobe(accStrobe), .accWide(accWide),
    .accWrite(accWrite), .modeSel(modeSel), .idxSel(idxSel), .idx0(idx0),
    .idx1(idx1), .pageReg(pageReg), .dptr(dptr), .wrData(wrData),
    .onChipSel(onChipSel), .offChipReq(offChipReq), .busAddr(busAddr),
    .hiAddrEn(hiAddrEn), .loAddrEn(loAddrEn), .ramRdData(ramRdData)
  );

  task automatic checkVal(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] effOf();
    return accWide ? dptr : {pageReg, (idxSel ? idx1 : idx0)};
  endfunction

  function automatic logic goesOff(input logic [1:0] m, input logic [15:0] ea);
    if (m == 2'b00) return 1'b0;
    if (m == 2'b11) return 1'b1;
    return ea >= 16'(ONCHIP);
  endfunction

  // Drive one access at a falling edge, predict, and check at the next falling edge.
  task automatic access(input string req, input logic [1:0] m, input logic w, input logic sel,
                        input logic [7:0] pg, input logic [7:0] i0, input logic [7:0] i1,
                        input logic [15:0] dp, input logic wr, input logic [7:0] wd);
    logic [15:0] ea;
    logic off, expHi;
    accStrobe = 1'b1; modeSel = m; accWide = w; idxSel = sel; pageReg = pg;
    idx0 = i0; idx1 = i1; dptr = dp; accWrite = wr; wrData = wd;
    ea = effOf();
    off = goesOff(m, ea);
    expHi = off && (w || m != 2'b01);
    if (off) expBus = expHi ? ea[11:0] : {4'h0, ea[7:0]};
    else if (wr) mem[ea[9:0]] = wd;
    else expRd = mem[ea[9:0]];
    @(negedge clk);
    checkVal(req, "onChipSel", 32'(onChipSel), 32'(!off));
    checkVal(req, "offChipReq", 32'(offChipReq), 32'(off));
    checkVal(req, "hiAddrEn", 32'(hiAddrEn), 32'(expHi));
    checkVal(req, "loAddrEn", 32'(loAddrEn), 32'(off));
    checkVal(req, "busAddr", 32'(busAddr), 32'(expBus));
    checkVal(req, "ramRdData", 32'(ramRdData), 32'(expRd));
  endtask

  task automatic idle();
    accStrobe = 1'b0;
    modeSel = 2'b11; accWide = 1'b1; dptr = 16'hFFFF;
    @(negedge clk);
    checkVal("R9", "idle selects", 32'({onChipSel, offChipReq, hiAddrEn, loAddrEn}), 32'h0);
    checkVal("R9", "idle busAddr", 32'(busAddr), 32'(expBus));
    checkVal("R10", "idle ramRdData", 32'(ramRdData), 32'(expRd));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11 reset state
    checkVal("R11", "reset outputs",
             32'({onChipSel, offChipReq, hiAddrEn, loAddrEn, busAddr, ramRdData}), 32'h0);
    rstN = 1'b1;

    // R1 fill every on-chip byte with wide writes in mode 00
    for (int a = 0; a < ONCHIP; a++)
      access("R1", 2'b00, 1'b1, 1'b0, 8'h0, 8'h0, 8'h0, 16'(a), 1'b1, 8'(a ^ (a >> 3)));
    // R1 wrap: write past the end lands on the first bytes
    access("R1", 2'b00, 1'b1, 1'b0, 8'h0, 8'h0, 8'h0, 16'(ONCHIP + 5), 1'b1, 8'hA5);
    access("R1", 2'b00, 1'b1, 1'b0, 8'h0, 8'h0, 8'h0, 16'h0005, 1'b0, 8'h0);
    access("R1", 2'b00, 1'b0, 1'b1, 8'hFF, 8'h0, 8'hFF, 16'h0, 1'b0, 8'h0);
    // R10 back-to-back write then read of same byte
    access("R10", 2'b01, 1'b0, 1'b0, 8'h02, 8'h44, 8'h0, 16'h0, 1'b1, 8'h3C);
    access("R10", 2'b01, 1'b1, 1'b0, 8'h0, 8'h0, 8'h0, 16'h0244, 1'b0, 8'h0);
    // R4 boundary, wide and narrow, both split modes
    access("R4", 2'b01, 1'b1, 1'b0, 8'h0, 8'h0, 8'h0, 16'(ONCHIP - 1), 1'b0, 8'h0);
    access("R7", 2'b01, 1'b1, 1'b0, 8'h0, 8'h0, 8'h0, 16'(ONCHIP), 1'b0, 8'h0);
    access("R4", 2'b10, 1'b0, 1'b0, 8'h03, 8'hFF, 8'h0, 16'h0, 1'b0, 8'h0);
    access("R8", 2'b10, 1'b0, 1'b1, 8'h04, 8'h0, 8'h33, 16'h0, 1'b1, 8'h77);
    // R6 narrow off-chip in mode 01 leaves the upper nibble undriven
    access("R6", 2'b01, 1'b0, 1'b1, 8'h0B, 8'h0, 8'h5A, 16'h0, 1'b0, 8'h0);
    access("R2", 2'b01, 1'b0, 1'b0, 8'h7C, 8'hC3, 8'h5A, 16'h0, 1'b0, 8'h0);
    // R3 / R7 wide access with high bits above the bus width
    access("R3", 2'b10, 1'b1, 1'b0, 8'h0, 8'h0, 8'h0, 16'hABCD, 1'b0, 8'h0);
    // R5 mode 11 low address still off-chip
    access("R5", 2'b11, 1'b0, 1'b0, 8'h00, 8'h10, 8'h0, 16'h0, 1'b1, 8'h99);
    access("R5", 2'b11, 1'b1, 1'b0, 8'h0, 8'h0, 8'h0, 16'h0000, 1'b0, 8'h0);
    // R10 off-chip write above did not touch byte 0x010
    access("R10", 2'b00, 1'b1, 1'b0, 8'h0, 8'h0, 8'h0, 16'h0010, 1'b0, 8'h0);
    idle();
    idle();

    // Random stream near the boundary, strobe mostly continuous
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] dp;
      dp = ($urandom % 4 == 0) ? 16'($urandom) : 16'(ONCHIP - 64 + ($urandom % 128));
      if ($urandom % 16 == 0) idle();
      access("R4", 2'($urandom), 1'($urandom), 1'($urandom), 8'($urandom % 8),
             8'($urandom), 8'($urandom), dp, 1'($urandom), 8'($urandom));
    end
    idle();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule